// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block scans the channels of an analogue multiplexer that feeds an external successive-approximation converter with a parallel 12-bit bus. For each channel it selects the input and waits a settle time. It then pulses the active-low chip-select with the read strobe high, which starts a conversion. From that start it keeps the multiplexer select frozen for a hold window, so the converter's track/hold can finish acquiring the sample.

The block does not read after a fixed delay. It waits until the converter's active-low end-of-conversion line shows completion, after a two-flop synchroniser. It then reads the bus by holding chip-select and read low together for a set number of cycles. The data is captured on the last cycle of that read. Each result leaves the block as a single-cycle valid pulse with the channel index and the data.

If completion is not seen within a timeout counted from the start, the block does not read at all. It sets a sticky error bit for that channel and moves on. Channels are visited in ascending order and wrap around. All windows are parameters in system clock cycles.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is asserted, chip-select and read are high, the mux select is 0, valid is low and every error bit is 0.
- R2: A conversion start is chip-select going low while read stays high. It happens exactly SETTLE_CYC cycles after the mux select changes, or after reset is released. Chip-select then stays low for exactly START_CYC cycles.
- R3: The mux select does not change for at least HOLD_CYC cycles after a conversion start. No read begins earlier than HOLD_CYC cycles after the start.
- R4: A read begins only after end-of-conversion (active low) has been seen low through the synchroniser. The read starts at the later of two cycles: start + HOLD_CYC, or the first low cycle of end-of-conversion + 3.
- R5: During a read, chip-select and read are low together for exactly RD_CYC cycles. Read is never low while chip-select is high.
- R6: The data bus value on the last read cycle is presented as the result. In the cycle the strobes rise, valid is high for exactly one cycle, together with the channel that was converted.
- R7: If end-of-conversion is not seen within TIMEOUT_CYC cycles of the start, the channel's error bit is set exactly TIMEOUT_CYC cycles after the start. No read takes place, no valid is produced and the scan moves to the next channel.
- R8: Error bits are sticky: once set, a bit stays set until reset.
- R9: Channels are converted in ascending order 0 to N_CH-1 and then wrap to 0. The select advances by one after each result or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_eoc_n | input | 1 | End-of-conversion from converter, low when done (asynchronous) |
| adc_data | input | DW | Converter parallel data bus |
| mux_sel | output | $clog2(N_CH) | Analogue multiplexer channel select |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | $clog2(N_CH) | Channel index of the result |
| res_data | output | DW | Conversion result |
| err_flags | output | N_CH | Sticky per-channel timeout flags |

## Verification
The hardest cases are those where end-of-conversion arrives before the hold window has closed, and those where it never arrives. Both need the converter model to depart from its usual timing. The bench models the converter with a random conversion length per start. It forces a few directed lengths: very short, just under the timeout, and missing on the last channel so that a timeout coincides with the wrap. Outside reads the bus model drives all-ones or all-zeros, so an early read shows up as wrong data.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int N_CH        = 8,
  parameter int DW          = 12,
  parameter int SETTLE_CYC  = 50,
  parameter int START_CYC   = 4,
  parameter int HOLD_CYC    = 200,
  parameter int TIMEOUT_CYC = 1000,
  parameter int RD_CYC      = 4,
  localparam int CH_W       = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            adc_cs_n,
  output logic            adc_rd_n,
  input  logic            adc_eoc_n,
  input  logic [DW-1:0]   adc_data,
  output logic [CH_W-1:0] mux_sel,
  output logic            res_valid,
  output logic [CH_W-1:0] res_chan,
  output logic [DW-1:0]   res_data,
  output logic [N_CH-1:0] err_flags
);

  localparam int TW = $clog2(TIMEOUT_CYC + SETTLE_CYC + RD_CYC + 1);
  localparam logic [TW-1:0] SETTLE_END = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] START_END  = TW'(START_CYC - 1);
  localparam logic [TW-1:0] HOLD_END   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] TOUT_END   = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] RD_END     = TW'(RD_CYC - 1);
  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(N_CH - 1);

  typedef enum logic [1:0] {S_SETTLE, S_START, S_WAIT, S_READ} state_t;

  state_t          state;
  logic [TW-1:0]   tmr;
  logic [CH_W-1:0] ch;
  logic [1:0]      eoc_q;
  logic            eoc_done;
  logic            hold_done;
  logic [CH_W-1:0] ch_next;

  assign eoc_done  = ~eoc_q[1];
  assign hold_done = (tmr >= HOLD_END);
  assign ch_next   = (ch == LAST_CH) ? '0 : ch + 1'b1;

  assign adc_cs_n = ~((state == S_START) || (state == S_READ));
  assign adc_rd_n = ~(state == S_READ);
  assign mux_sel  = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_SETTLE;
      tmr       <= '0;
      ch        <= '0;
      eoc_q     <= 2'b11;
      err_flags <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      eoc_q     <= {eoc_q[0], adc_eoc_n};
      res_valid <= 1'b0;
      tmr       <= tmr + 1'b1;
      case (state)
        S_SETTLE: begin
          if (tmr == SETTLE_END) begin
            state <= S_START;
            tmr   <= '0;
          end
        end
        S_START: begin
          if (tmr == START_END) state <= S_WAIT;
        end
        S_WAIT: begin
          if (hold_done && eoc_done) begin
            state <= S_READ;
            tmr   <= '0;
          end else if (tmr == TOUT_END) begin
            err_flags[ch] <= 1'b1;
            ch            <= ch_next;
            state         <= S_SETTLE;
            tmr           <= '0;
          end
        end
        S_READ: begin
          if (tmr == RD_END) begin
            res_data  <= adc_data;
            res_chan  <= ch;
            res_valid <= 1'b1;
            ch        <= ch_next;
            state     <= S_SETTLE;
            tmr       <= '0;
          end
        end
        default: state <= S_SETTLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int N_CH     = 8,
  parameter int HOLD_CYC = 200,
  localparam int CH_W    = $clog2(N_CH),
  localparam int HW      = $clog2(HOLD_CYC + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_cs_n,
  input logic            adc_rd_n,
  input logic            adc_eoc_n,
  input logic [CH_W-1:0] mux_sel,
  input logic            res_valid,
  input logic [N_CH-1:0] err_flags
);

  logic          cs_prev;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev <= 1'b1;
      hcnt    <= '0;
    end else begin
      cs_prev <= adc_cs_n;
      if (cs_prev && !adc_cs_n && adc_rd_n) hcnt <= HW'(1);
      else if (hcnt != '0 && hcnt < HW'(HOLD_CYC - 1)) hcnt <= hcnt + 1'b1;
      else hcnt <= '0;
    end
  end

  AST_RD_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n); // R5

  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != '0) |-> $stable(mux_sel)); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_flags) & ~err_flags) == '0)); // R8

  AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> !$past(adc_eoc_n, 3)); // R4

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.N_CH(N_CH), .HOLD_CYC(HOLD_CYC)) chk_i (.*);

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int DW  = 12;
  localparam int SET = 8;
  localparam int STC = 3;
  localparam int HLD = 20;
  localparam int TO  = 120;
  localparam int RDC = 3;
  localparam int CW  = $clog2(N);
  localparam int NCONV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_cs_n, adc_rd_n;
  logic adc_eoc_n = 1'b1;
  logic [DW-1:0] adc_data;
  logic [CW-1:0] mux_sel, res_chan;
  logic res_valid;
  logic [DW-1:0] res_data;
  logic [N-1:0] err_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(.N_CH(N), .DW(DW), .SETTLE_CYC(SET), .START_CYC(STC),
    .HOLD_CYC(HLD), .TIMEOUT_CYC(TO), .RD_CYC(RDC)) dut_i (
    .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_eoc_n(adc_eoc_n), .adc_data(adc_data), .mux_sel(mux_sel),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .err_flags(err_flags));

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int start_cyc = 0, eoc_cyc = 0, rdf_cyc = 0, mux_cyc = 0;
  int conv_len = 0, nconv = 0, pend = 0;
  logic [DW-1:0] conv_val = '0;
  logic done = 1'b0;
  logic [CW-1:0] exp_ch = '0;
  logic [N-1:0] exp_err = '0;
  logic prev_cs = 1'b1, prev_rd = 1'b1;
  logic [CW-1:0] prev_mux = '0;

  assign adc_data = (!adc_rd_n && !adc_cs_n && done) ? conv_val : (nconv[0] ? '1 : '0);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int pick_len(input int idx);
    int r;
    if (idx == 0) return 2;
    if (idx == 3 || idx == 7) return 0;
    if (idx == 6) return TO - 10;
    r = $urandom % 10;
    if (r == 0) return 0;
    if (r < 3) return 1 + $urandom % 15;
    return 20 + $urandom % (TO - 30);
  endfunction

  function automatic logic [CW-1:0] nxt(input logic [CW-1:0] c);
    return (c == CW'(N-1)) ? '0 : c + 1'b1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (mux_sel != prev_mux) begin
        chk(mux_sel == nxt(prev_mux), "R9 mux order", mux_sel, nxt(prev_mux));
        chk(cyc - start_cyc >= HLD, "R3 mux change in hold", cyc - start_cyc, HLD);
        mux_cyc = cyc;
      end
      if (prev_cs && !adc_cs_n && adc_rd_n) begin
        chk(cyc - mux_cyc == SET, "R2 settle", cyc - mux_cyc, SET);
        chk(mux_sel == exp_ch, "R9 start channel", mux_sel, exp_ch);
        chk(pend == 0, "R7 lost conversion", pend, 0);
        chk(err_flags == exp_err, "R8 error flags", err_flags, exp_err);
        conv_len = pick_len(nconv);
        conv_val = DW'(1 + $urandom % 4094);
        pend = (conv_len == 0) ? 2 : 1;
        start_cyc = cyc;
        done = 1'b0;
        adc_eoc_n = 1'b1;
        nconv++;
      end else if (!prev_cs && adc_cs_n && prev_rd) begin
        chk(cyc - start_cyc == STC, "R2 start pulse", cyc - start_cyc, STC);
      end
      if (pend == 1 && !done && cyc - start_cyc == conv_len) begin
        adc_eoc_n = 1'b0;
        done = 1'b1;
        eoc_cyc = cyc;
      end
      if (prev_rd && !adc_rd_n) begin
        int e;
        e = (start_cyc + HLD > eoc_cyc + 3) ? start_cyc + HLD : eoc_cyc + 3;
        chk(!adc_cs_n, "R5 cs with rd", adc_cs_n, 0);
        chk(pend == 1 && done, "R4 read before eoc", done, 1);
        chk(cyc == e, "R4 read start cycle", cyc, e);
        rdf_cyc = cyc;
      end
      if (!prev_rd && adc_rd_n) begin
        chk(cyc - rdf_cyc == RDC, "R5 read length", cyc - rdf_cyc, RDC);
        chk(res_valid == 1'b1, "R6 valid", res_valid, 1);
        chk(res_chan == exp_ch, "R6 channel", res_chan, exp_ch);
        chk(res_data == conv_val, "R6 data", res_data, conv_val);
        pend = 0;
        exp_ch = nxt(exp_ch);
      end else if (res_valid) begin
        chk(1'b0, "R7 unexpected valid", 1, 0);
      end
      if (pend == 2 && cyc - start_cyc == TO - 1)
        chk(err_flags == exp_err, "R7 early error", err_flags, exp_err);
      if (pend == 2 && cyc - start_cyc == TO) begin
        exp_err[exp_ch] = 1'b1;
        chk(err_flags == exp_err, "R7 timeout flag", err_flags, exp_err);
        chk(adc_rd_n && adc_cs_n, "R7 no read on timeout", adc_rd_n, 1);
        pend = 0;
        exp_ch = nxt(exp_ch);
      end
    end
    prev_cs = adc_cs_n;
    prev_rd = adc_rd_n;
    prev_mux = mux_sel;
  end

  initial begin
    bit fin;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_rd_n, "R1 strobes in reset", {adc_cs_n, adc_rd_n}, 3);
    chk(mux_sel == 0 && !res_valid, "R1 mux/valid in reset", mux_sel, 0);
    chk(err_flags == 0, "R1 errors in reset", err_flags, 0);
    mux_cyc = cyc;
    rst_n = 1'b1;
    fin = 1'b0;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      if (nconv >= NCONV && pend == 0 && adc_cs_n) begin
        fin = 1'b1;
        break;
      end
    end
    chk(fin, "watchdog", 0, 1);
    chk(exp_err != 0, "R7 timeouts exercised", exp_err, 1);
    chk(err_flags == exp_err, "R8 final flags", err_flags, exp_err);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err_flags == 0, "R1 errors cleared by reset", err_flags, 0);
    chk(adc_cs_n && adc_rd_n && mux_sel == 0 && !res_valid, "R1 state after reset", mux_sel, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule